// File: doc/BRIEF.md
# Set-Associative Cache Tag Array

This block holds the tags for a 4-way set-associative cache of 256 KB. The cache has 1024 sets and 64-byte lines. A lookup port takes a full address and reads every way of the indexed set. One cycle later it reports whether a way matched, and which one. The block stores tags only. Data, line fill, writeback and the choice of a victim way belong to the blocks around it.

Each stored entry holds three things:
- a valid flag;
- the architectural tag taken from the upper address bits;
- one extra bit that normal allocation sets to the most significant set-index bit.

A lookup compares that extra bit against the same address bit, so the extra bit has to agree with the set where the entry sits. A debug port can write and read any entry, with every field supplied directly. A debug write can therefore store an extra bit that disagrees with its set. Such an entry still reads back as valid, but it can never produce a hit.

After reset the block sweeps every set to invalid, one set per cycle. It raises a busy flag for the whole sweep and ignores all requests until the sweep is done.

Top module: `cache_tag_array`

## Requirements
- R1: The address splits into three fields: line offset `addr[LINE_BITS-1:0]`, set `addr[LINE_BITS+SET_BITS-1:LINE_BITS]`, and tag (the remaining upper bits). A lookup hits a way when that way's entry in the indexed set is valid, its stored tag equals the address tag, and its stored extra bit equals the set field's most significant bit. Offset bits never affect the result.
- R2: `lk_valid_o` is high in exactly the cycle after an accepted `lk_req_i`, and `lk_hit_o`/`lk_way_o` are valid in that cycle. On a miss, `lk_way_o` is 0, and both are 0 whenever `lk_valid_o` is low.
- R3: A valid entry whose stored extra bit differs from its set's most significant index bit never hits.
- R4: An entry whose valid flag is 0 never hits.
- R5: When more than one way of a set matches, `lk_way_o` reports the lowest-numbered matching way.
- R6: A debug write stores `dbg_tag_i` and `dbg_vld_i` into the way `dbg_way_i` of set `dbg_set_i`. In `dbg_tag_i`, the top bit is the extra bit and the lower bits are the tag. A debug read of that set and way raises `dbg_ack_o` in the next cycle, with the stored fields on `dbg_rtag_o` (same layout) and `dbg_rvld_o`.
- R7: When a debug write and a lookup address the same set in the same cycle, the write is performed and the lookup result reflects the contents from before the write.
- R8: After reset is released, `busy_o` stays high for exactly SETS cycles, and every entry of every way is left invalid.
- R9: While `busy_o` is high, lookups, debug reads and debug writes are ignored: no `lk_valid_o`, no `dbg_ack_o`, and no change to any entry.
- R10: When a debug write and a debug read target the same entry in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the invalidation sweep |
| busy_o | output | 1 | High while the reset sweep runs |
| lk_req_i | input | 1 | Lookup request strobe |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_valid_o | output | 1 | Lookup result valid (cycle after request) |
| lk_hit_o | output | 1 | Lookup matched a way |
| lk_way_o | output | WAY_W | Matching way, lowest index on multiple matches |
| dbg_wr_i | input | 1 | Debug write strobe |
| dbg_rd_i | input | 1 | Debug read strobe |
| dbg_set_i | input | SET_BITS | Debug set index |
| dbg_way_i | input | WAY_W | Debug way select |
| dbg_tag_i | input | TAG_W+1 | Debug write tag, top bit is the extra bit |
| dbg_vld_i | input | 1 | Debug write valid flag |
| dbg_ack_o | output | 1 | Debug read data valid |
| dbg_rtag_o | output | TAG_W+1 | Debug read tag including extra bit |
| dbg_rvld_o | output | 1 | Debug read valid flag |

## Verification
The bench builds the block with a 12-bit address, 16 sets, 4-byte lines and 4 ways, giving 6-bit tags with address bit 5 as the set MSB. This size allows an exhaustive debug readback of all 64 entries and a lookup of every stored tag in every set, each at a varying line offset. Sets in both halves of the index range can be given deliberately mismatched extra bits. The reset sweep is short enough to count cycle by cycle, and requests can be injected partway through it. Same-cycle collisions between a debug write and a lookup, and between a debug write and a debug read, are each driven once against a bench-side model of every entry.

// File: rtl/tagarr_pkg.sv
package tagarr_pkg;
  typedef enum logic {ST_CLEAR = 1'b0, ST_RUN = 1'b1} tagarr_state_e;
endpackage

// File: rtl/tagarr_way_ram.sv
module tagarr_way_ram #(
  parameter int IDX_W = 10,
  parameter int DW    = 18
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             re_a_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [DW-1:0]    rdata_a_o,
  input  logic             re_b_i,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [DW-1:0]    rdata_b_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-first: both ports return contents from before a same-cycle write
  always_ff @(posedge clk) begin
    if (re_a_i) rdata_a_o <= mem[raddr_a_i];
  end

  always_ff @(posedge clk) begin
    if (re_b_i) rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/tagarr_init_ctrl.sv
module tagarr_init_ctrl
  import tagarr_pkg::*;
#(
  parameter int SET_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  output logic                busy_o,
  output logic [SET_BITS-1:0] clr_set_o
);
  localparam logic [SET_BITS-1:0] LAST_SET = '1;

  tagarr_state_e       st_q;
  logic [SET_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_CLEAR;
      cnt_q <= '0;
    end else if (st_q == ST_CLEAR) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_SET) st_q <= ST_RUN;
    end
  end

  assign busy_o    = (st_q == ST_CLEAR);
  assign clr_set_o = cnt_q;
endmodule

// File: rtl/tagarr_match.sv
module tagarr_match #(
  parameter int WAYS  = 4,
  parameter int STW   = 17,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][STW:0] ent_i,
  input  logic [STW-1:0]         key_i,
  output logic                   hit_o,
  output logic [WAY_W-1:0]       way_o
);
  logic [WAYS-1:0] hv;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hv[g] = ent_i[g][STW] && (ent_i[g][STW-1:0] == key_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hv[i]) way_o = WAY_W'(i);
    end
    hit_o = |hv;
  end
endmodule

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
  parameter int ADDR_W    = 32,
  parameter int SET_BITS  = 10,
  parameter int LINE_BITS = 6,
  parameter int WAYS      = 4,
  localparam int TAG_W    = ADDR_W - SET_BITS - LINE_BITS,
  localparam int STW      = TAG_W + 1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  output logic                busy_o,
  input  logic                lk_req_i,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  output logic                lk_valid_o,
  output logic                lk_hit_o,
  output logic [WAY_W-1:0]    lk_way_o,
  input  logic                dbg_wr_i,
  input  logic                dbg_rd_i,
  input  logic [SET_BITS-1:0] dbg_set_i,
  input  logic [WAY_W-1:0]    dbg_way_i,
  input  logic [STW-1:0]      dbg_tag_i,
  input  logic                dbg_vld_i,
  output logic                dbg_ack_o,
  output logic [STW-1:0]      dbg_rtag_o,
  output logic                dbg_rvld_o
);
  localparam int EW      = STW + 1;
  localparam int SET_LO  = LINE_BITS;
  localparam int SET_MSB = LINE_BITS + SET_BITS - 1;

  logic                      busy;
  logic [SET_BITS-1:0]       clr_set;
  logic [SET_BITS-1:0]       lk_set;
  logic [STW-1:0]            lk_key, lk_key_q;
  logic                      lk_go, rd_go, wr_go;
  logic                      lk_pend_q, rd_pend_q;
  logic [WAY_W-1:0]          rd_way_q;
  logic [SET_BITS-1:0]       wr_set;
  logic [EW-1:0]             wr_data;
  logic [WAYS-1:0][EW-1:0]   rd_a, rd_b;
  logic                      m_hit;
  logic [WAY_W-1:0]          m_way;

  tagarr_init_ctrl #(.SET_BITS(SET_BITS)) u_init (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy),
    .clr_set_o (clr_set)
  );

  assign lk_go  = lk_req_i && !busy;
  assign rd_go  = dbg_rd_i && !busy;
  assign wr_go  = dbg_wr_i && !busy;
  assign lk_set = lk_addr_i[SET_MSB:SET_LO];
  // compare key: extra bit taken from the set MSB, then the address tag
  assign lk_key = {lk_addr_i[SET_MSB], lk_addr_i[ADDR_W-1:SET_MSB+1]};

  assign wr_set  = busy ? clr_set : dbg_set_i;
  assign wr_data = busy ? '0 : {dbg_vld_i, dbg_tag_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = busy || (wr_go && (dbg_way_i == WAY_W'(w)));

    tagarr_way_ram #(.IDX_W(SET_BITS), .DW(EW)) u_ram (
      .clk       (clk),
      .we_i      (way_we),
      .waddr_i   (wr_set),
      .wdata_i   (wr_data),
      .re_a_i    (lk_go),
      .raddr_a_i (lk_set),
      .rdata_a_o (rd_a[w]),
      .re_b_i    (rd_go),
      .raddr_b_i (dbg_set_i),
      .rdata_b_o (rd_b[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
      lk_key_q  <= '0;
      rd_way_q  <= '0;
    end else begin
      lk_pend_q <= lk_go;
      rd_pend_q <= rd_go;
      if (lk_go) lk_key_q <= lk_key;
      if (rd_go) rd_way_q <= dbg_way_i;
    end
  end

  tagarr_match #(.WAYS(WAYS), .STW(STW), .WAY_W(WAY_W)) u_match (
    .ent_i (rd_a),
    .key_i (lk_key_q),
    .hit_o (m_hit),
    .way_o (m_way)
  );

  assign busy_o     = busy;
  assign lk_valid_o = lk_pend_q;
  assign lk_hit_o   = lk_pend_q && m_hit;
  assign lk_way_o   = (lk_pend_q && m_hit) ? m_way : '0;
  assign dbg_ack_o  = rd_pend_q;
  assign dbg_rtag_o = rd_b[rd_way_q][STW-1:0];
  assign dbg_rvld_o = rd_b[rd_way_q][STW];
endmodule

// File: rtl/tagarr_chk.sv
module tagarr_chk (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic lk_req_i,
  input logic lk_valid_o,
  input logic lk_hit_o,
  input logic dbg_rd_i,
  input logic dbg_ack_o
);
  // R2
  lk_result_origin_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid_o |-> $past(lk_req_i && !busy_o));

  // R2
  lk_result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_req_i && !busy_o) |=> lk_valid_o);

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit_o |-> lk_valid_o);

  // R6
  dbg_ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_i && !busy_o) |=> dbg_ack_o);

  // R9
  dbg_ack_origin_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_ack_o |-> $past(dbg_rd_i && !busy_o));

  // R8
  busy_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !busy_o);
endmodule

bind cache_tag_array tagarr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .lk_req_i   (lk_req_i),
  .lk_valid_o (lk_valid_o),
  .lk_hit_o   (lk_hit_o),
  .dbg_rd_i   (dbg_rd_i),
  .dbg_ack_o  (dbg_ack_o)
);

// File: tb/cache_tag_array_bench.sv
module cache_tag_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int SB   = 4;
  localparam int LB   = 2;
  localparam int NW   = 4;
  localparam int NS   = 1 << SB;
  localparam int TW   = AW - SB - LB;
  localparam int STW  = TW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy;
  logic lk_req = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_valid, lk_hit;
  logic [1:0] lk_way;
  logic dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [SB-1:0] dbg_set = '0;
  logic [1:0] dbg_way = '0;
  logic [STW-1:0] dbg_tag = '0;
  logic dbg_vld = 1'b0;
  logic dbg_ack, dbg_rvld;
  logic [STW-1:0] dbg_rtag;

  int errors = 0;
  int checks = 0;

  int mtag [NS][NW];
  bit mx   [NS][NW];
  bit mv   [NS][NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_array #(.ADDR_W(AW), .SET_BITS(SB), .LINE_BITS(LB), .WAYS(NW)) u_cache_tag_array (
    .clk(clk), .rst(rst), .busy_o(busy),
    .lk_req_i(lk_req), .lk_addr_i(lk_addr),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_way_o(lk_way),
    .dbg_wr_i(dbg_wr), .dbg_rd_i(dbg_rd), .dbg_set_i(dbg_set), .dbg_way_i(dbg_way),
    .dbg_tag_i(dbg_tag), .dbg_vld_i(dbg_vld),
    .dbg_ack_o(dbg_ack), .dbg_rtag_o(dbg_rtag), .dbg_rvld_o(dbg_rvld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int tag, input int s, input int off);
    return AW'((tag << (SB + LB)) | (s << LB) | (off & ((1 << LB) - 1)));
  endfunction

  // expected lookup result from the model: lowest valid way with matching tag and extra bit
  task automatic expect_lk(input int tag, input int s, output bit hit, output int way);
    hit = 0; way = 0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (mv[s][w] && mtag[s][w] == tag && mx[s][w] == s[SB-1]) begin
        hit = 1; way = w;
      end
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mtag[s][w] = 0; mx[s][w] = 0; mv[s][w] = 0;
      end
  endtask

  task automatic dwrite(input int s, input int w, input bit x, input int tag, input bit v);
    @(negedge clk);
    dbg_wr = 1'b1; dbg_set = SB'(s); dbg_way = 2'(w);
    dbg_tag = {x, TW'(tag)}; dbg_vld = v;
    @(negedge clk);
    dbg_wr = 1'b0;
    mtag[s][w] = tag; mx[s][w] = x; mv[s][w] = v;
  endtask

  task automatic dread(input int s, input int w, input string req);
    logic [STW-1:0] exp_t;
    @(negedge clk);
    dbg_rd = 1'b1; dbg_set = SB'(s); dbg_way = 2'(w);
    @(negedge clk);
    dbg_rd = 1'b0;
    exp_t = {mx[s][w], TW'(mtag[s][w])};
    chk(dbg_ack === 1'b1, req, int'(dbg_ack), 1);
    chk(dbg_rtag === exp_t, req, int'(dbg_rtag), int'(exp_t));
    chk(dbg_rvld === mv[s][w], req, int'(dbg_rvld), int'(mv[s][w]));
  endtask

  task automatic lookup(input int tag, input int s, input int off, input string req);
    bit eh; int ew;
    expect_lk(tag, s, eh, ew);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = mk_addr(tag, s, off);
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_valid === 1'b1, req, int'(lk_valid), 1);
    chk(lk_hit === eh, req, int'(lk_hit), int'(eh));
    chk(int'(lk_way) == ew, req, int'(lk_way), ew);
  endtask

  task automatic do_reset_and_count();
    int n;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    // R8: busy held during reset
    chk(busy === 1'b1, "R8 busy in reset", int'(busy), 1);
    chk(lk_valid === 1'b0 && dbg_ack === 1'b0, "R2 idle outputs in reset",
        int'(lk_valid), 0);
    rst = 1'b0;
    n = 0;
    while (busy === 1'b1 && n < 10 * NS) begin
      n++;
      @(negedge clk);
    end
    chk(n == NS, "R8 busy length", n, NS);
    clear_model();
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit eh; int ew;
    do_reset_and_count();

    // R8: sweep leaves all entries invalid
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) dread(s, w, "R8 invalid after reset");

    // fill with correct extra bit, a few mismatches (R3) and invalids (R4)
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        bit x; bit v;
        x = s[SB-1];
        if ((s % 4) == 3 && w == 2) x = ~x;
        v = !((s % 5) == 1 && w == 3);
        dwrite(s, w, x, (s * 7 + w * 13 + 5) & 63, v);
      end

    // R6: exhaustive readback, mismatched entries still read valid
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) dread(s, w, "R6 readback");

    // R1, R3, R4: lookup every stored tag at varying offsets, plus a miss
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        string r;
        r = (mx[s][w] != s[SB-1]) ? "R3 mismatched extra bit" :
            (!mv[s][w]) ? "R4 invalid entry" : "R1 lookup hit";
        lookup(mtag[s][w], s, s + w, r);
      end
      lookup((mtag[s][0] + 32) & 63, s, 1, "R1 lookup miss");
    end

    // R3 explicit: mismatch entry in upper half set 11 way 2 must miss
    expect_lk(mtag[11][2], 11, eh, ew);
    chk(eh == 0, "R3 model sanity", int'(eh), 0);
    lookup(mtag[11][2], 11, 0, "R3 upper-half mismatch");

    // R5: duplicate tag in ways 1 and 3 of set 6
    dwrite(6, 1, 1'b0, 40, 1'b1);
    dwrite(6, 3, 1'b0, 40, 1'b1);
    lookup(40, 6, 2, "R5 lowest way wins");
    chk(int'(lk_way) == 1, "R5 way index", int'(lk_way), 1);

    // R4: invalidate way 1, way 3 now reports
    dwrite(6, 1, 1'b0, 40, 1'b0);
    lookup(40, 6, 3, "R4 invalidated way");
    chk(int'(lk_way) == 3, "R4 next way", int'(lk_way), 3);

    // R7: same-cycle debug write and lookup to set 9 way 0
    begin
      int old_t; int new_t;
      old_t = mtag[9][0];
      new_t = (old_t + 17) & 63;
      @(negedge clk);
      dbg_wr = 1'b1; dbg_set = 4'd9; dbg_way = 2'd0;
      dbg_tag = {1'b1, TW'(new_t)}; dbg_vld = 1'b1;
      lk_req = 1'b1; lk_addr = mk_addr(old_t, 9, 0);
      @(negedge clk);
      dbg_wr = 1'b0; lk_req = 1'b0;
      chk(lk_hit === 1'b1, "R7 lookup sees old", int'(lk_hit), 1);
      chk(int'(lk_way) == 0, "R7 old way", int'(lk_way), 0);
      mtag[9][0] = new_t; mx[9][0] = 1'b1; mv[9][0] = 1'b1;
      lookup(new_t, 9, 1, "R7 new tag after write");
      lookup(old_t, 9, 1, "R7 old tag gone");
    end

    // R10: same-cycle debug write and read of set 2 way 1
    begin
      logic [STW-1:0] old_f;
      old_f = {mx[2][1], TW'(mtag[2][1])};
      @(negedge clk);
      dbg_wr = 1'b1; dbg_rd = 1'b1; dbg_set = 4'd2; dbg_way = 2'd1;
      dbg_tag = {1'b0, TW'(63)}; dbg_vld = 1'b1;
      @(negedge clk);
      dbg_wr = 1'b0; dbg_rd = 1'b0;
      chk(dbg_rtag === old_f, "R10 read returns old", int'(dbg_rtag), int'(old_f));
      mtag[2][1] = 63; mx[2][1] = 1'b0; mv[2][1] = 1'b1;
      dread(2, 1, "R10 new contents");
    end

    // R9: requests during the sweep are ignored
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    lk_req = 1'b1; lk_addr = mk_addr(5, 0, 0);
    dbg_rd = 1'b1; dbg_wr = 1'b1; dbg_set = 4'd0; dbg_way = 2'd0;
    dbg_tag = {1'b0, TW'(5)}; dbg_vld = 1'b1;
    @(negedge clk);
    lk_req = 1'b0; dbg_rd = 1'b0; dbg_wr = 1'b0;
    chk(lk_valid === 1'b0, "R9 no lookup response", int'(lk_valid), 0);
    chk(dbg_ack === 1'b0, "R9 no debug ack", int'(dbg_ack), 0);
    while (busy === 1'b1) @(negedge clk);
    clear_model();
    dread(0, 0, "R9 write during busy dropped");
    lookup(5, 0, 0, "R9 no hit after dropped write");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule